// File: doc/BRIEF.md
# Three-Decade BCD Counter with Hold Register and Digit Scan

This block counts events on a count strobe in three binary-coded decimal decades, so one unit runs from 000 to 999. A separate hold register takes a copy of the running count for display. While the load control is high the copy follows the counter, and while it is low the shown value stays frozen as counting goes on. The held value is presented one decade at a time. A one-hot, active-high digit select steps from the units decade up to the hundreds decade, advancing once per scan tick. The decade it points at appears both as a BCD nibble and as seven-segment data for common-cathode displays.

When the count wraps from 999 to 000 the unit raises a one-cycle overflow pulse. Feeding that pulse into the count strobe of a second unit gives a six-digit counter reaching 999,999. The two units share reset, load control and scan tick, so their digit selects stay identical and a single set of digit strobes can serve both. Each unit keeps its own BCD and segment outputs. Every input is sampled on the single system clock. The count strobe and scan tick are one-cycle clock enables, and the external scan oscillator supplies the scan tick at its chosen rate. None of the pins carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `bcd3_scan_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the hold register clear to 000, `digit_sel` becomes 3'b001 and `ovf` becomes 0.
- R2: Each edge with `cnt_pulse` high and `rst` low raises the three-decade BCD count by one, and 999 wraps to 000. Each decade holds 0 to 9. Counting does not depend on `hold_load`.
- R3: `ovf` is high for exactly the one cycle after the edge at which a `cnt_pulse` wrapped the count from 999 to 000, and it is low at all other times.
- R4: At an edge with `hold_load` high, the hold register takes the count value as it stood before that edge. At an edge with `hold_load` low, the held value does not change.
- R5: `digit_sel` is one-hot and active-high, with bit 0 standing for units, bit 1 for tens and bit 2 for hundreds. Each edge with `scan_tick` high moves it to the next higher bit, and 3'b100 returns to 3'b001. Without `scan_tick` it holds.
- R6: `bcd_digit` shows the held decade that `digit_sel` points at.
- R7: `seg` is the active-high decode of `bcd_digit`, with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F hex.
- R8: When a second unit takes the first unit's `ovf` as its `cnt_pulse` and shares `rst`, `hold_load` and `scan_tick`, the pair counts in six decades and both units drive the same `digit_sel` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_pulse | input | 1 | One-cycle count strobe |
| hold_load | input | 1 | High: hold register follows the count; low: hold register frozen |
| scan_tick | input | 1 | One-cycle strobe that advances the digit select |
| digit_sel | output | 3 | One-hot digit strobe, bit 0 = units |
| bcd_digit | output | 4 | BCD value of the selected held decade |
| seg | output | 7 | Seven-segment data, bit 0 = a through bit 6 = g, active high |
| ovf | output | 1 | One-cycle pulse after a wrap from 999 to 000 |

## Verification
The bench drives the count up to 999 several times and checks the wrap. A carry chain that breaks at a decade boundary would show 9 followed by A, or would lose the hundreds increment. An overflow raised on the wrong cycle, or held high for two cycles, would give the upper unit of the cascade a wrong count. Some phases keep the hold load low while counting continues, which catches a hold register that leaks new values or a counter that stops along with it. Scan ticks arrive at random, including several in a row, to catch a select that skips a position, wraps wrongly or drifts between the two cascaded units.

// File: rtl/bcdscan_pkg.sv
package bcdscan_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcdscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inc_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q;

  always_ff @(posedge clk) begin
    if (rst)
      val_q <= '0;
    else if (inc_i)
      val_q <= (val_q == bcd_t'(9)) ? '0 : val_q + bcd_t'(1);
  end

  assign val_o   = val_q;
  assign carry_o = inc_i && (val_q == bcd_t'(9));

  assert_decade_range_R2: assert property (@(posedge clk) disable iff (rst)
    val_q <= bcd_t'(9));
  assert_decade_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_i && val_q != bcd_t'(9)) |=> (val_q == $past(val_q) + bcd_t'(1)));
endmodule

// File: rtl/digit_scan.sv
module digit_scan #(
  parameter int DECADES = 3,
  localparam int IW = (DECADES > 1) ? $clog2(DECADES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  output logic [DECADES-1:0] sel_o,
  output logic [IW-1:0]      idx_o
);
  logic [DECADES-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= DECADES'(1);
    else if (tick_i)
      sel_q <= {sel_q[DECADES-2:0], sel_q[DECADES-1]};
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < DECADES; i++)
      if (sel_q[i]) idx_o = IW'(i);
  end

  assign sel_o = sel_q;

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_q) == 1);
  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(sel_q));
endmodule

// File: rtl/hold_mux.sv
module hold_mux
  import bcdscan_pkg::*;
#(
  parameter int DECADES = 3,
  localparam int IW = (DECADES > 1) ? $clog2(DECADES) : 1,
  localparam int VW = DECADES * BCD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [VW-1:0] cnt_i,
  input  logic [IW-1:0] idx_i,
  output bcd_t          digit_o
);
  logic [VW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)
      hold_q <= '0;
    else if (load_i)
      hold_q <= cnt_i;
  end

  always_comb begin
    digit_o = '0;
    for (int i = 0; i < DECADES; i++)
      if (idx_i == IW'(i)) digit_o = hold_q[i*BCD_W +: BCD_W];
  end

  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(hold_q));
  assert_hold_copy_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (hold_q == $past(cnt_i)));
endmodule

// File: rtl/seg7_decode.sv
module seg7_decode
  import bcdscan_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_o
);
  always_comb begin
    unique case (digit_i)
      4'd0: seg_o = 7'h3F;
      4'd1: seg_o = 7'h06;
      4'd2: seg_o = 7'h5B;
      4'd3: seg_o = 7'h4F;
      4'd4: seg_o = 7'h66;
      4'd5: seg_o = 7'h6D;
      4'd6: seg_o = 7'h7D;
      4'd7: seg_o = 7'h07;
      4'd8: seg_o = 7'h7F;
      4'd9: seg_o = 7'h6F;
      default: seg_o = 7'h00;
    endcase
  end
endmodule

// File: rtl/bcd3_scan_counter.sv
module bcd3_scan_counter
  import bcdscan_pkg::*;
#(
  parameter int DECADES = 3,
  localparam int IW = (DECADES > 1) ? $clog2(DECADES) : 1,
  localparam int VW = DECADES * BCD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_pulse,
  input  logic               hold_load,
  input  logic               scan_tick,
  output logic [DECADES-1:0] digit_sel,
  output logic [3:0]         bcd_digit,
  output logic [6:0]         seg,
  output logic               ovf
);
  logic [DECADES:0] inc_chain;
  logic [VW-1:0]    count_vec;
  logic [IW-1:0]    sel_idx;
  bcd_t             cur_digit;
  logic             ovf_q;

  assign inc_chain[0] = cnt_pulse;

  for (genvar g = 0; g < DECADES; g++) begin : g_decade
    bcd_t dval;
    bcd_decade u_dec (
      .clk    (clk),
      .rst    (rst),
      .inc_i  (inc_chain[g]),
      .val_o  (dval),
      .carry_o(inc_chain[g+1])
    );
    assign count_vec[g*BCD_W +: BCD_W] = dval;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= inc_chain[DECADES];
  end

  digit_scan #(.DECADES(DECADES)) u_scan (
    .clk   (clk),
    .rst   (rst),
    .tick_i(scan_tick),
    .sel_o (digit_sel),
    .idx_o (sel_idx)
  );

  hold_mux #(.DECADES(DECADES)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (hold_load),
    .cnt_i  (count_vec),
    .idx_i  (sel_idx),
    .digit_o(cur_digit)
  );

  seg7_decode u_seg (
    .digit_i(cur_digit),
    .seg_o  (seg)
  );

  assign bcd_digit = cur_digit;
  assign ovf       = ovf_q;

  assert_ovf_single_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> !ovf);
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(cnt_pulse));
  assert_ovf_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (count_vec == '0));
  assert_digit_bcd_R6: assert property (@(posedge clk) disable iff (rst)
    bcd_digit <= 4'd9);
endmodule

// File: tb/bcd3_scan_counter_tb.sv
module bcd3_scan_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1, cnt_pulse = 1'b0, hold_load = 1'b0, scan_tick = 1'b0;
  logic [2:0] sel_lo, sel_hi;
  logic [3:0] dig_lo, dig_hi;
  logic [6:0] seg_lo, seg_hi;
  logic ovf_lo, ovf_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd3_scan_counter u_dut (
    .clk(clk), .rst(rst), .cnt_pulse(cnt_pulse), .hold_load(hold_load),
    .scan_tick(scan_tick), .digit_sel(sel_lo), .bcd_digit(dig_lo),
    .seg(seg_lo), .ovf(ovf_lo));

  bcd3_scan_counter u_hi (
    .clk(clk), .rst(rst), .cnt_pulse(ovf_lo), .hold_load(hold_load),
    .scan_tick(scan_tick), .digit_sel(sel_hi), .bcd_digit(dig_hi),
    .seg(seg_hi), .ovf(ovf_hi));

  int errors = 0, checks = 0, cycles = 0;
  int m_cnt = 0, m_hold = 0, m_sel = 0, m_ovf = 0;
  int h_cnt = 0, h_hold = 0;
  bit done = 0;

  function automatic int digit_of(int v, int idx);
    int p = 1;
    for (int i = 0; i < idx; i++) p = p * 10;
    return (v / p) % 10;
  endfunction

  function automatic logic [6:0] seg_ref(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cycles, act, exp);
    end
  endtask

  task automatic compare();
    int ed = digit_of(m_hold, m_sel);
    int eh = digit_of(h_hold, m_sel);
    chk(sel_lo == 3'(1 << m_sel), "R5 digit_sel", sel_lo, 1 << m_sel);
    chk(dig_lo == 4'(ed), "R2/R4/R6 bcd_digit", dig_lo, ed);
    chk(seg_lo == seg_ref(ed), "R7 seg", seg_lo, seg_ref(ed));
    chk(ovf_lo == m_ovf[0], "R3 ovf", ovf_lo, m_ovf);
    chk(sel_hi == sel_lo, "R8 shared digit_sel", sel_hi, sel_lo);
    chk(dig_hi == 4'(eh), "R8 upper bcd_digit", dig_hi, eh);
    chk(seg_hi == seg_ref(eh), "R8 upper seg", seg_hi, seg_ref(eh));
  endtask

  task automatic step(bit r, bit p, bit l, bit t);
    rst = r; cnt_pulse = p; hold_load = l; scan_tick = t;
    if (r) begin
      m_cnt = 0; m_hold = 0; m_sel = 0; m_ovf = 0; h_cnt = 0; h_hold = 0;
    end else begin
      int n_ovf = (p && m_cnt == 999) ? 1 : 0;
      if (l) begin m_hold = m_cnt; h_hold = h_cnt; end
      if (m_ovf != 0) h_cnt = (h_cnt + 1) % 1000;
      if (p) m_cnt = (m_cnt + 1) % 1000;
      if (t) m_sel = (m_sel + 1) % 3;
      m_ovf = n_ovf;
    end
    @(negedge clk);
    cycles++;
    compare();
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 1, 1);
    step(1, 0, 0, 0);
    // R1: reset state
    chk(sel_lo == 3'b001, "R1 sel after reset", sel_lo, 1);
    chk(dig_lo == 4'd0, "R1 digit after reset", dig_lo, 0);
    chk(ovf_lo == 1'b0, "R1 ovf after reset", ovf_lo, 0);
    // R5: tick on every cycle, nothing counting
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1);
    // R2/R3: dense counting through several wraps, latch open
    for (int i = 0; i < 3200; i++)
      step(0, 1, 1, ($urandom_range(0, 3) == 0));
    // R4: freeze display while counting continues
    for (int i = 0; i < 400; i++)
      step(0, ($urandom_range(0, 1) == 1), 0, 1'($urandom_range(0, 1)));
    // R4: reopen the hold register
    for (int i = 0; i < 12; i++) step(0, 0, 1, 1);
    // random mix through more wraps
    for (int i = 0; i < 4000; i++)
      step(0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0),
           ($urandom_range(0, 2) == 0));
    // R1: reset mid-run, then count to the wrap again
    step(1, 1, 1, 1);
    chk(dig_lo == 4'd0 && sel_lo == 3'b001, "R1 mid-run reset", dig_lo, 0);
    for (int i = 0; i < 1010; i++) step(0, 1, 1, (i % 3 == 0));
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule